// File: doc/BRIEF.md
# Buzzer Tone Generator with Envelope

This block drives a square-wave buzzer from a 32.768 kHz reference strobe. A 3-bit code picks one of eight tones, each a whole divisor of the reference rate. A second 3-bit code picks one of eight loudness levels. Loudness is set by the share of each tone period that the output spends high, not by amplitude. Sound comes out while the continuous enable is set or while a one-shot burst runs.

An optional envelope takes over the level. It starts at the loudest level and moves one level softer after each fixed step time, then stays at the softest level. The envelope controller has three states. `ENV_OFF` moves to `ENV_WALK` when the envelope is switched on. `ENV_WALK` steps the level, moves to `ENV_HOLD` when it reaches level code 7, and moves back to `ENV_WALK` on a restart. Both `ENV_WALK` and `ENV_HOLD` return to `ENV_OFF` when the envelope is switched off.

The one-shot controller has two states. `OS_IDLE` moves to `OS_RUN` on an accepted trigger. `OS_RUN` returns to `OS_IDLE` when its width has elapsed or when stop is asserted. All timing counts reference strobes only, so the system clock can run at any rate above the reference rate.

Top module: `buzz_tone_top`

## Requirements
- R1: After reset, with every control input at 0, `buzz_o` and `os_busy_o` are both 0.
- R2: The tone period is D reference ticks. Tone codes 0 to 7 give D = 8, 10, 12, 14, 16, 20, 24, 28 (D = 8+2c for c<4, D = 16+4(c-4) otherwise).
- R3: With level code k (0 is loudest, 7 is softest), each period starts with a high phase of floor((D*(8-k)+8)/16) reference ticks, followed by a low phase for the rest of the period.
- R4: While neither `cont_en_i` nor a one-shot is active, `buzz_o` is 0. When sound starts, the first reference tick of the period is high.
- R5: While the envelope is on, `level_sel_i` is ignored. The level starts at code 0 and goes up by one code every 2048 ticks when `env_slow_i`=0, or every 4096 ticks when `env_slow_i`=1. When the envelope is off, `level_sel_i` sets the level.
- R6: Once the envelope reaches code 7, it stays at code 7.
- R7: A pulse on `env_rst_i` while the envelope is on puts the level back to code 0 and restarts the step timer.
- R8: An accepted trigger holds `os_busy_o` high for 1024 ticks when `os_long_i`=0 or 4096 ticks when `os_long_i`=1, and the tone sounds during that time.
- R9: `os_stop_i` ends a running one-shot at the next clock edge, and the output goes silent.
- R10: A trigger is ignored while `cont_en_i` is 1 or while a one-shot is already running.
- R11: All counting advances only on cycles where `ref_tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | One-cycle strobe at the reference rate |
| tone_sel_i | input | 3 | Tone code |
| level_sel_i | input | 3 | Level code used when the envelope is off |
| cont_en_i | input | 1 | Continuous sound enable |
| env_on_i | input | 1 | Envelope enable |
| env_rst_i | input | 1 | Envelope restart pulse |
| env_slow_i | input | 1 | Envelope rate: 1 selects the long step |
| os_trig_i | input | 1 | One-shot trigger pulse |
| os_long_i | input | 1 | One-shot width: 1 selects the long burst |
| os_stop_i | input | 1 | One-shot early stop pulse |
| buzz_o | output | 1 | Buzzer square wave |
| os_busy_o | output | 1 | High while a one-shot runs |

## Verification
The bench sweeps all 64 tone and level pairs and measures the high phase and the period. Rounding the high time the wrong way or using the wrong divisor shows up as a one-tick miscount. It samples the envelope in the middle of every step, at both rates, and after it should be holding. A design that wraps past code 7, ignores the rate bit, or lets `level_sel_i` through would read the wrong high time there. The one-shot checks include an exact burst length, a trigger during a burst, a trigger while continuous sound is on, and an early stop. A design that restarts the burst, or accepts a trigger it should ignore, changes the busy count. A run with a strobe every third cycle catches any counter that advances on the system clock instead of the strobe.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

    typedef enum logic [1:0] {
        ENV_OFF  = 2'd0,
        ENV_WALK = 2'd1,
        ENV_HOLD = 2'd2
    } env_state_t;

    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_RUN  = 1'b1
    } os_state_t;

    localparam int DIV_W = 5;

    // reference ticks per tone period
    function automatic logic [DIV_W-1:0] tone_div(input logic [2:0] code);
        logic [DIV_W-1:0] d;
        if (code[2] == 1'b0) d = 5'd8 + {2'b00, code[1:0], 1'b0};
        else                 d = 5'd16 + {1'b0, code[1:0], 2'b00};
        return d;
    endfunction

    // high ticks: round(div * (8 - lvl) / 16)
    function automatic logic [DIV_W-1:0] high_ticks(input logic [DIV_W-1:0] div,
                                                     input logic [2:0] lvl);
        logic [8:0] prod;
        prod = 9'(div) * 9'(4'd8 - {1'b0, lvl}) + 9'd8;
        return prod[8:4];
    endfunction

endpackage

// File: rtl/buzz_tone_osc.sv
module buzz_tone_osc
    import buzz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick_i,
    input  logic       active_i,
    input  logic [2:0] tone_sel_i,
    input  logic [2:0] level_i,
    output logic       buzz_o
);
    localparam logic [DIV_W-1:0] MAX_DIV = 5'd28;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] div_w;
    logic [DIV_W-1:0] hi_w;

    assign div_w = tone_div(tone_sel_i);
    assign hi_w  = high_ticks(div_w, level_i);

    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            phase_q <= '0;
        end else if (ref_tick_i) begin
            if (phase_q >= div_w - 5'd1) phase_q <= '0;
            else                         phase_q <= phase_q + 5'd1;
        end
    end

    assign buzz_o = active_i && (phase_q < hi_w);

    AST_PHASE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < MAX_DIV);  // R2
    AST_FIRST_TICK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_i) |-> buzz_o);  // R4

endmodule

// File: rtl/buzz_env_fsm.sv
module buzz_env_fsm
    import buzz_pkg::*;
#(
    parameter int STEP_FAST = 2048,
    parameter int STEP_SLOW = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick_i,
    input  logic       env_on_i,
    input  logic       env_rst_i,
    input  logic       env_slow_i,
    output logic       env_act_o,
    output logic [2:0] env_lvl_o
);
    localparam int CW = $clog2(STEP_SLOW);
    localparam logic [CW-1:0] LAST_FAST = CW'(STEP_FAST - 1);
    localparam logic [CW-1:0] LAST_SLOW = CW'(STEP_SLOW - 1);

    env_state_t    state_q, state_d;
    logic [CW-1:0] step_q;
    logic [2:0]    lvl_q;
    logic [CW-1:0] last_w;
    logic          step_done_w;

    assign last_w      = env_slow_i ? LAST_SLOW : LAST_FAST;
    assign step_done_w = ref_tick_i && (step_q >= last_w);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENV_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENV_OFF:  if (env_on_i) state_d = ENV_WALK;
            ENV_WALK: begin
                if (!env_on_i)                         state_d = ENV_OFF;
                else if (env_rst_i)                    state_d = ENV_WALK;
                else if (step_done_w && lvl_q == 3'd6) state_d = ENV_HOLD;
            end
            ENV_HOLD: begin
                if (!env_on_i)      state_d = ENV_OFF;
                else if (env_rst_i) state_d = ENV_WALK;
            end
            default: state_d = ENV_OFF;
        endcase
    end

    // level and step timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            step_q <= '0;
        end else begin
            unique case (state_q)
                ENV_OFF: begin
                    lvl_q  <= '0;
                    step_q <= '0;
                end
                ENV_WALK: begin
                    if (env_rst_i) begin
                        lvl_q  <= '0;
                        step_q <= '0;
                    end else if (step_done_w) begin
                        lvl_q  <= lvl_q + 3'd1;
                        step_q <= '0;
                    end else if (ref_tick_i) begin
                        step_q <= step_q + 1'b1;
                    end
                end
                ENV_HOLD: begin
                    if (env_rst_i) begin
                        lvl_q  <= '0;
                        step_q <= '0;
                    end
                end
                default: begin
                    lvl_q  <= '0;
                    step_q <= '0;
                end
            endcase
        end
    end

    assign env_act_o = (state_q != ENV_OFF);
    assign env_lvl_o = lvl_q;

    AST_ENV_HOLD_AT_SOFTEST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENV_HOLD) |-> (lvl_q == 3'd7));  // R6
    AST_ENV_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENV_WALK && env_on_i && !env_rst_i)
        |=> (lvl_q == $past(lvl_q) || lvl_q == $past(lvl_q) + 3'd1));  // R5
    AST_ENV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ENV_OFF && env_on_i && env_rst_i) |=> (lvl_q == 3'd0));  // R7

endmodule

// File: rtl/buzz_oneshot_fsm.sv
module buzz_oneshot_fsm
    import buzz_pkg::*;
#(
    parameter int WIDTH_SHORT = 1024,
    parameter int WIDTH_LONG  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick_i,
    input  logic cont_en_i,
    input  logic trig_i,
    input  logic long_i,
    input  logic stop_i,
    output logic busy_o
);
    localparam int CW = $clog2(WIDTH_LONG);
    localparam logic [CW-1:0] LAST_SHORT = CW'(WIDTH_SHORT - 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(WIDTH_LONG - 1);

    os_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OS_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE: if (trig_i && !cont_en_i && !stop_i) state_d = OS_RUN;
            OS_RUN: begin
                if (stop_i)                              state_d = OS_IDLE;
                else if (ref_tick_i && cnt_q >= last_q)  state_d = OS_IDLE;
            end
            default: state_d = OS_IDLE;
        endcase
    end

    // width latch and tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= LAST_SHORT;
        end else begin
            unique case (state_q)
                OS_IDLE: begin
                    cnt_q  <= '0;
                    last_q <= long_i ? LAST_LONG : LAST_SHORT;
                end
                OS_RUN: if (ref_tick_i) cnt_q <= cnt_q + 1'b1;
                default: cnt_q <= '0;
            endcase
        end
    end

    assign busy_o = (state_q == OS_RUN);

    AST_STOP_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !busy_o);  // R9
    AST_TRIG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OS_IDLE && cont_en_i) |=> (state_q == OS_IDLE));  // R10
    AST_BURST_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q <= last_q));  // R8

endmodule

// File: rtl/buzz_tone_top.sv
module buzz_tone_top
    import buzz_pkg::*;
#(
    parameter int REF_HZ = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick_i,
    input  logic [2:0] tone_sel_i,
    input  logic [2:0] level_sel_i,
    input  logic       cont_en_i,
    input  logic       env_on_i,
    input  logic       env_rst_i,
    input  logic       env_slow_i,
    input  logic       os_trig_i,
    input  logic       os_long_i,
    input  logic       os_stop_i,
    output logic       buzz_o,
    output logic       os_busy_o
);
    localparam int STEP_FAST   = REF_HZ / 16;
    localparam int STEP_SLOW   = REF_HZ / 8;
    localparam int WIDTH_SHORT = REF_HZ / 32;
    localparam int WIDTH_LONG  = REF_HZ / 8;

    logic       env_act;
    logic [2:0] env_lvl;
    logic [2:0] eff_lvl;
    logic       sound_on;

    buzz_env_fsm #(
        .STEP_FAST (STEP_FAST),
        .STEP_SLOW (STEP_SLOW)
    ) u_env (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick_i),
        .env_on_i   (env_on_i),
        .env_rst_i  (env_rst_i),
        .env_slow_i (env_slow_i),
        .env_act_o  (env_act),
        .env_lvl_o  (env_lvl)
    );

    buzz_oneshot_fsm #(
        .WIDTH_SHORT (WIDTH_SHORT),
        .WIDTH_LONG  (WIDTH_LONG)
    ) u_oneshot (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick_i),
        .cont_en_i  (cont_en_i),
        .trig_i     (os_trig_i),
        .long_i     (os_long_i),
        .stop_i     (os_stop_i),
        .busy_o     (os_busy_o)
    );

    assign eff_lvl  = env_act ? env_lvl : level_sel_i;
    assign sound_on = cont_en_i || os_busy_o;

    buzz_tone_osc u_osc (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick_i),
        .active_i   (sound_on),
        .tone_sel_i (tone_sel_i),
        .level_i    (eff_lvl),
        .buzz_o     (buzz_o)
    );

    AST_SILENT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_en_i && !os_busy_o) |-> !buzz_o);  // R4

endmodule

// File: tb/buzz_tone_top_bench.sv
module buzz_tone_top_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_tick;
    logic [2:0] tone_sel, level_sel;
    logic       cont_en, env_on, env_rst, env_slow;
    logic       os_trig, os_long, os_stop;
    logic       buzz, os_busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int tick_gap = 1;
    int gap_cnt  = 0;
    bit done     = 0;

    always #2 clk = ~clk;  // 250 MHz

    buzz_tone_top u_buzz_tone_top (
        .clk (clk), .rst_n (rst_n), .ref_tick_i (ref_tick),
        .tone_sel_i (tone_sel), .level_sel_i (level_sel),
        .cont_en_i (cont_en), .env_on_i (env_on), .env_rst_i (env_rst),
        .env_slow_i (env_slow), .os_trig_i (os_trig), .os_long_i (os_long),
        .os_stop_i (os_stop), .buzz_o (buzz), .os_busy_o (os_busy)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (gap_cnt >= tick_gap - 1) begin
            ref_tick <= 1'b1;
            gap_cnt  <= 0;
        end else begin
            ref_tick <= 1'b0;
            gap_cnt  <= gap_cnt + 1;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected under 150000", cyc);
            finish_run();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_div(input int c);
        return (c < 4) ? 8 + 2 * c : 16 + 4 * (c - 4);
    endfunction

    function automatic int exp_hi(input int d, input int k);
        return (d * (8 - k) + 8) / 16;
    endfunction

    task automatic measure(output int hi, output int per);
        int lo;
        @(negedge clk);
        while (buzz) @(negedge clk);
        while (!buzz) @(negedge clk);
        hi = 0;
        while (buzz) begin hi++; @(negedge clk); end
        lo = 0;
        while (!buzz) begin lo++; @(negedge clk); end
        per = hi + lo;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk) os_trig = 1'b1;
        @(negedge clk) os_trig = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (os_busy) begin n++; @(negedge clk); end
    endtask

    initial begin
        int hi, per, n, t0, highs;
        rst_n = 0; tone_sel = 0; level_sel = 0; cont_en = 0; env_on = 0;
        env_rst = 0; env_slow = 0; os_trig = 0; os_long = 0; os_stop = 0;
        repeat (8) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check("R1 buzz after reset", buzz, 0);
        check("R1 busy after reset", os_busy, 0);

        // R2 / R3: full tone x level sweep
        cont_en = 1;
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 8; k++) begin
                tone_sel = 3'(c); level_sel = 3'(k);
                repeat (60) @(negedge clk);
                measure(hi, per);
                check($sformatf("R2 period tone %0d lvl %0d", c, k), per, exp_div(c));
                check($sformatf("R3 high tone %0d lvl %0d", c, k), hi, exp_hi(exp_div(c), k));
            end
        end

        // R11: strobe every third cycle
        tick_gap = 3; tone_sel = 3'd2; level_sel = 3'd0;
        repeat (120) @(negedge clk);
        measure(hi, per);
        check("R11 period with gapped strobe", per, 3 * 12);
        check("R11 high with gapped strobe", hi, 3 * 6);
        tick_gap = 1;

        // R4: silent when idle, first tick high on start
        cont_en = 0;
        repeat (5) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (buzz) highs++; end
        check("R4 silent while idle", highs, 0);
        cont_en = 1;
        @(negedge clk);
        check("R4 first tick high", buzz, 1);

        // R5 envelope, fast rate, level_sel ignored
        tone_sel = 3'd7; level_sel = 3'd7; env_slow = 0;
        @(negedge clk) env_on = 1;
        t0 = cyc;
        for (int k = 0; k < 8; k++) begin
            wait_until(t0 + k * 2048 + 1024);
            measure(hi, per);
            check($sformatf("R5 envelope step %0d", k), hi, exp_hi(28, k));
        end
        // R6 hold at softest
        wait_until(t0 + 8 * 2048 + 3000);
        measure(hi, per);
        check("R6 hold at code 7", hi, exp_hi(28, 7));

        // R7 restart
        @(negedge clk) env_rst = 1;
        @(negedge clk) env_rst = 0;
        t0 = cyc;
        measure(hi, per);
        check("R7 restart to code 0", hi, exp_hi(28, 0));
        wait_until(t0 + 2048 + 1024);
        measure(hi, per);
        check("R7 step timer restarted", hi, exp_hi(28, 1));

        // R5 slow rate
        env_slow = 1;
        @(negedge clk) env_rst = 1;
        @(negedge clk) env_rst = 0;
        t0 = cyc;
        wait_until(t0 + 3072);
        measure(hi, per);
        check("R5 slow rate still code 0", hi, exp_hi(28, 0));
        wait_until(t0 + 6144);
        measure(hi, per);
        check("R5 slow rate code 1", hi, exp_hi(28, 1));

        // R5 envelope off: level_sel back in use
        env_on = 0; level_sel = 3'd3;
        repeat (40) @(negedge clk);
        measure(hi, per);
        check("R5 level_sel used when envelope off", hi, exp_hi(28, 3));
        cont_en = 0; env_slow = 0;
        repeat (10) @(negedge clk);

        // R8 one-shot widths
        tone_sel = 3'd0; level_sel = 3'd0; os_long = 0;
        pulse_trig();
        count_busy(n);
        check("R8 short burst length", n, 1024);
        check("R8 silent after burst", buzz, 0);
        os_long = 1;
        pulse_trig();
        count_busy(n);
        check("R8 long burst length", n, 4096);
        os_long = 0;
        pulse_trig();
        measure(hi, per);
        check("R8 tone during burst", per, 8);
        count_busy(n);

        // R10 retrigger during burst ignored
        repeat (5) @(negedge clk);
        pulse_trig();
        n = 0;
        while (os_busy) begin
            n++;
            if (n == 300) os_trig = 1'b1;
            if (n == 301) os_trig = 1'b0;
            @(negedge clk);
        end
        os_trig = 1'b0;
        check("R10 retrigger ignored", n, 1024);

        // R10 trigger ignored with continuous enable
        @(negedge clk) begin cont_en = 1; os_trig = 1; end
        @(negedge clk) begin cont_en = 0; os_trig = 0; end
        repeat (3) @(negedge clk);
        check("R10 trigger blocked busy", os_busy, 0);
        check("R10 trigger blocked buzz", buzz, 0);

        // R9 early stop
        os_long = 1;
        pulse_trig();
        repeat (200) @(negedge clk);
        check("R9 running before stop", os_busy, 1);
        os_stop = 1;
        @(negedge clk) os_stop = 0;
        check("R9 busy cleared by stop", os_busy, 0);
        highs = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (buzz) highs++; end
        check("R9 silent after stop", highs, 0);

        finish_run();
    end

endmodule